// File: doc/BRIEF.md
# Serial Register Access Port

This block is a serial slave that gives a host access to a small bank of byte registers over a chip-select, a serial clock and one or two data lines. Every transfer opens with a 16-bit instruction that carries a read/write flag, a two-bit length code and a 13-bit register address. Data bytes follow the instruction. The address steps after each byte, and the direction of that step depends on the selected bit order.

Writes to the general registers land in a shadow (buffer) copy. The values that the rest of the chip sees on `act_regs_o` change only when the host writes a 1 into bit 0 of the commit register. That bit never holds a value. A port configuration register selects the bit order and whether read data leaves on the shared data line or on a separate output.

The serial pins are sampled in the system clock domain. SCLK must therefore stay high and low for at least three system clock cycles per phase.

Top module: `spi_reg_ctrl`

## Requirements
- R1: The instruction has 16 bits: bit 15 is read (1) or write (0), bits 14:13 are the length code and bits 12:0 are the address. In MSB-first mode bit 15 is the first bit after chip-select falls, and the data bytes that follow are also sent MSB first.
- R2: Length code 00 moves 1 byte, 01 moves 2 bytes and 10 moves 3 bytes. SCLK cycles after the last byte, while chip-select stays low, write nothing and leave both output enables low.
- R3: Length code 11 moves bytes until chip-select rises.
- R4: In MSB-first mode each byte after the first goes to the address one below the byte before it.
- R5: When bit 1 of the configuration register (address 0x000) is 1, the next transfer runs LSB first. The instruction arrives with bit 0 first and bit 15 last, data bytes arrive and leave with bit 0 first, and the address rises by one for each byte.
- R6: An address with any of bits 12:10 set selects nothing. A write to it changes no register, and a read from it returns 0x00. Reads from unmapped addresses also return 0x00.
- R7: A write to one of the eight general registers (addresses 0x010 to 0x017) changes the shadow copy, and a read returns that shadow value. `act_regs_o` does not change (register i sits at bits 8i+7:8i).
- R8: A write to address 0x232 with bit 0 set copies all eight shadow registers to `act_regs_o` within 6 clock cycles of the SCLK rise that completes the byte. A write with bit 0 clear copies nothing. A read of 0x232 returns 0x00.
- R9: Read data bits change only after SCLK falls. The first bit is valid after the fall that follows the 16th SCLK rise, and each bit stays valid until the next SCLK rise.
- R10: When bit 0 of the configuration register is 0 (the reset value), read data leaves on `spi_sdio_o` with `spi_sdio_oe` high and `spi_sdo_oe` low. When it is 1, read data leaves on `spi_sdo_o` with `spi_sdo_oe` high and `spi_sdio_oe` low.
- R11: If chip-select rises at any point, the transfer is abandoned. A byte that is only partly received is discarded, and the next transfer starts again with an instruction.
- R12: After reset every register reads 0x00, `act_regs_o` is zero, the port runs MSB first in shared-line mode, and both output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| spi_cs_n | input | 1 | Chip-select, active low |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_sdio_i | input | 1 | Shared data line, input side |
| spi_sdio_o | output | 1 | Shared data line, output side |
| spi_sdio_oe | output | 1 | Output enable for the shared data line |
| spi_sdo_o | output | 1 | Separate read data output |
| spi_sdo_oe | output | 1 | Output enable for the separate read output |
| act_regs_o | output | 64 | Active register values, register i at bits 8i+7:8i |

## Verification
Each serial pin passes through two synchronizer stages and one edge register. A read bit therefore appears three clock cycles after the SCLK fall that launches it. The bench holds each SCLK phase for four cycles and samples the data and enable pins just before it raises SCLK. A commit reaches `act_regs_o` four cycles after the SCLK rise that completes its byte. The bench compares the active value against its model on every clock. It accepts either the old or the new value for up to six cycles after that rise and requires the new value from then on. Shadow contents are checked only through serial reads, byte by byte, in every bit order and pin mode.

// File: rtl/spi_ctl_pkg.sv
// Package: shared constants and types for the serial register access port.
// Assumes a 13-bit address and byte-wide registers.
package spi_ctl_pkg;

    localparam int ADDR_W = 13;
    localparam int DATA_W = 8;

    // Frame sequencing states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INSTR = 2'd1,
        ST_DATA  = 2'd2,
        ST_DONE  = 2'd3
    } frame_st_t;

    // Transfer length codes carried in the instruction
    typedef enum logic [1:0] {
        LEN_ONE    = 2'b00,
        LEN_TWO    = 2'b01,
        LEN_THREE  = 2'b10,
        LEN_STREAM = 2'b11
    } len_code_t;

endpackage

// File: rtl/spi_pin_sync.sv
// Module: brings chip-select, SCLK and the data input into the system clock
// domain and produces one-cycle SCLK edge pulses.
// Assumes each SCLK phase lasts at least STAGES+1 system clocks and that data
// is stable around the SCLK rising edge.
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic sclk_i,
    input  logic sdio_i,
    output logic cs_act_o,
    output logic sclk_rise_o,
    output logic sclk_fall_o,
    output logic sdi_o
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] cs_sh, ck_sh, dt_sh;
    logic              ck_last;

    // Synchronizer chains and the previous SCLK level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_sh   <= '1;
            ck_sh   <= '0;
            dt_sh   <= '0;
            ck_last <= 1'b0;
        end else begin
            cs_sh[0] <= cs_n_i;
            ck_sh[0] <= sclk_i;
            dt_sh[0] <= sdio_i;
            for (int k = 1; k < STAGES; k++) begin
                cs_sh[k] <= cs_sh[k-1];
                ck_sh[k] <= ck_sh[k-1];
                dt_sh[k] <= dt_sh[k-1];
            end
            ck_last <= ck_sh[LAST];
        end
    end

    assign cs_act_o    = ~cs_sh[LAST];
    assign sclk_rise_o = ck_sh[LAST] & ~ck_last;
    assign sclk_fall_o = ~ck_sh[LAST] & ck_last;
    assign sdi_o       = dt_sh[LAST];

endmodule

// File: rtl/spi_frame_ctrl.sv
// Module: collects the instruction, counts data bytes, steps the address and
// shifts read data out. It issues one write strobe per completed write byte.
// Assumes the edge pulses come from spi_pin_sync and that the bit order is
// fixed for the length of a transfer.
module spi_frame_ctrl
    import spi_ctl_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_act_i,
    input  logic          sclk_rise_i,
    input  logic          sclk_fall_i,
    input  logic          sdi_i,
    input  logic          cfg_lsb_i,
    input  logic          cfg_four_wire_i,
    input  logic [DW-1:0] rd_data_i,
    output logic [AW-1:0] rd_addr_o,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o,
    output logic          dout_o,
    output logic          sdio_oe_o,
    output logic          sdo_oe_o
);

    localparam int INSTR_W = AW + 3;
    localparam int CNT_W   = $clog2(INSTR_W);
    localparam logic [CNT_W-1:0] INSTR_LAST = CNT_W'(INSTR_W - 1);
    localparam logic [CNT_W-1:0] BYTE_LAST  = CNT_W'(DW - 1);

    frame_st_t          state_q;
    logic [CNT_W-1:0]   bit_cnt_q;
    logic [INSTR_W-1:0] instr_q, instr_nx;
    logic [DW-1:0]      data_q, data_nx, out_q;
    logic [AW-1:0]      addr_q, addr_step;
    len_code_t          len_q;
    logic [1:0]         byte_q;
    logic               rd_q, lsb_q, load_q, dout_q, drive;
    logic               wr_en_q;
    logic [AW-1:0]      wr_addr_q;
    logic [DW-1:0]      wr_data_q;

    // Next shift values and address step for the latched bit order
    always_comb begin
        instr_nx  = lsb_q ? {sdi_i, instr_q[INSTR_W-1:1]} : {instr_q[INSTR_W-2:0], sdi_i};
        data_nx   = lsb_q ? {sdi_i, data_q[DW-1:1]}       : {data_q[DW-2:0], sdi_i};
        addr_step = lsb_q ? addr_q + 1'b1 : addr_q - 1'b1;
    end

    // Frame sequencing, byte counting and read shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
            instr_q   <= '0;
            data_q    <= '0;
            out_q     <= '0;
            dout_q    <= 1'b0;
            addr_q    <= '0;
            len_q     <= LEN_ONE;
            byte_q    <= '0;
            rd_q      <= 1'b0;
            lsb_q     <= 1'b0;
            load_q    <= 1'b0;
            wr_en_q   <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else begin
            wr_en_q <= 1'b0;
            load_q  <= 1'b0;
            if (load_q) out_q <= rd_data_i;
            if (!cs_act_i) begin
                state_q   <= ST_IDLE;
                bit_cnt_q <= '0;
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        state_q   <= ST_INSTR;
                        bit_cnt_q <= '0;
                        lsb_q     <= cfg_lsb_i;
                    end
                    ST_INSTR: if (sclk_rise_i) begin
                        instr_q <= instr_nx;
                        if (bit_cnt_q == INSTR_LAST) begin
                            state_q   <= ST_DATA;
                            bit_cnt_q <= '0;
                            rd_q      <= instr_nx[INSTR_W-1];
                            len_q     <= len_code_t'(instr_nx[INSTR_W-2:INSTR_W-3]);
                            addr_q    <= instr_nx[AW-1:0];
                            byte_q    <= '0;
                            load_q    <= instr_nx[INSTR_W-1];
                        end else begin
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (sclk_rise_i) begin
                            data_q <= data_nx;
                            if (bit_cnt_q == BYTE_LAST) begin
                                bit_cnt_q <= '0;
                                byte_q    <= byte_q + 1'b1;
                                addr_q    <= addr_step;
                                if (!rd_q) begin
                                    wr_en_q   <= 1'b1;
                                    wr_addr_q <= addr_q;
                                    wr_data_q <= data_nx;
                                end
                                if (len_q != LEN_STREAM && byte_q == 2'(len_q))
                                    state_q <= ST_DONE;
                                else
                                    load_q <= rd_q;
                            end else begin
                                bit_cnt_q <= bit_cnt_q + 1'b1;
                            end
                        end
                        if (sclk_fall_i && rd_q) begin
                            dout_q <= lsb_q ? out_q[0] : out_q[DW-1];
                            out_q  <= lsb_q ? (out_q >> 1) : (out_q << 1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign drive     = (state_q == ST_DATA) && rd_q;
    assign sdio_oe_o = drive && !cfg_four_wire_i;
    assign sdo_oe_o  = drive && cfg_four_wire_i;
    assign dout_o    = dout_q;
    assign rd_addr_o = addr_q;
    assign wr_en_o   = wr_en_q;
    assign wr_addr_o = wr_addr_q;
    assign wr_data_o = wr_data_q;

    // R10: only one data pin is ever driven
    p_oe_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(sdio_oe_o && sdo_oe_o));

    // R2: a write strobe only follows an SCLK rising edge
    p_wr_after_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(sclk_rise_i));

    // R11: a released chip-select turns off the read drivers
    p_cs_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act_i |=> !(sdio_oe_o || sdo_oe_o));

    // R9: read data changes only after an SCLK falling edge
    p_dout_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout_q) |-> $past(sclk_fall_i));

endmodule

// File: rtl/spi_reg_bank.sv
// Module: holds the shadow and active copies of the general registers, the
// port configuration register and the commit decode.
// Assumes at most one write strobe per cycle. Read data is combinational.
module spi_reg_bank
    import spi_ctl_pkg::*;
#(
    parameter int NUM_REGS  = 8,
    parameter int AW        = ADDR_W,
    parameter int DW        = DATA_W,
    parameter int BANK_BASE = 16,
    parameter int CFG_ADDR  = 0,
    parameter int UPD_ADDR  = 562
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [AW-1:0]          wr_addr_i,
    input  logic [DW-1:0]          wr_data_i,
    input  logic [AW-1:0]          rd_addr_i,
    output logic [DW-1:0]          rd_data_o,
    output logic                   cfg_lsb_o,
    output logic                   cfg_four_wire_o,
    output logic [NUM_REGS*DW-1:0] act_flat_o
);

    localparam int LOC_W = 10;

    logic [NUM_REGS-1:0][DW-1:0] buf_q, act_q;
    logic [NUM_REGS-1:0]         hit;
    logic [1:0]                  cfg_q;
    logic                        upd_hit, cfg_hit;

    function automatic logic sel(input logic [AW-1:0] a, input int loc);
        return (a[AW-1:LOC_W] == '0) && (a[LOC_W-1:0] == LOC_W'(loc));
    endfunction

    // Per-register write decode
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
        assign hit[g] = wr_en_i && sel(wr_addr_i, BANK_BASE + g);
    end

    assign upd_hit = wr_en_i && sel(wr_addr_i, UPD_ADDR) && wr_data_i[0];
    assign cfg_hit = wr_en_i && sel(wr_addr_i, CFG_ADDR);

    // Shadow writes, commit copy and configuration update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
            act_q <= '0;
            cfg_q <= '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++)
                if (hit[i]) buf_q[i] <= wr_data_i;
            if (upd_hit) act_q <= buf_q;
            if (cfg_hit) cfg_q <= wr_data_i[1:0];
        end
    end

    // Read multiplexer; commit and unmapped addresses read as zero
    always_comb begin
        rd_data_o = '0;
        if (sel(rd_addr_i, CFG_ADDR)) rd_data_o = DW'(cfg_q);
        for (int i = 0; i < NUM_REGS; i++)
            if (sel(rd_addr_i, BANK_BASE + i)) rd_data_o = buf_q[i];
    end

    assign cfg_four_wire_o = cfg_q[0];
    assign cfg_lsb_o       = cfg_q[1];
    assign act_flat_o      = act_q;

    // R6: writes with upper address bits set change nothing
    p_upper_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i[AW-1:LOC_W] != '0) |=> ($stable(buf_q) && $stable(cfg_q)));

    // R8: a commit copies the shadow set seen at the write
    p_update_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        upd_hit |=> (act_q == $past(buf_q)));

    // R7: without a commit the active values hold
    p_act_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_hit |=> $stable(act_q));

endmodule

// File: rtl/spi_reg_ctrl.sv
// Module: top level of the serial register access port. It ties the pin
// synchronizer, the frame controller and the register bank together.
// Assumes the host idles SCLK low and changes data while SCLK is low.
module spi_reg_ctrl
    import spi_ctl_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       spi_cs_n,
    input  logic                       spi_sclk,
    input  logic                       spi_sdio_i,
    output logic                       spi_sdio_o,
    output logic                       spi_sdio_oe,
    output logic                       spi_sdo_o,
    output logic                       spi_sdo_oe,
    output logic [NUM_REGS*DATA_W-1:0] act_regs_o
);

    logic              cs_act, sclk_rise, sclk_fall, sdi;
    logic              cfg_lsb, cfg_four_wire, wr_en, dout;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_data, wr_data;

    spi_pin_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .cs_n_i(spi_cs_n), .sclk_i(spi_sclk),
        .sdio_i(spi_sdio_i), .cs_act_o(cs_act), .sclk_rise_o(sclk_rise),
        .sclk_fall_o(sclk_fall), .sdi_o(sdi)
    );

    spi_frame_ctrl #(.AW(ADDR_W), .DW(DATA_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .cs_act_i(cs_act), .sclk_rise_i(sclk_rise),
        .sclk_fall_i(sclk_fall), .sdi_i(sdi), .cfg_lsb_i(cfg_lsb),
        .cfg_four_wire_i(cfg_four_wire), .rd_data_i(rd_data),
        .rd_addr_o(rd_addr), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
        .wr_data_o(wr_data), .dout_o(dout), .sdio_oe_o(spi_sdio_oe),
        .sdo_oe_o(spi_sdo_oe)
    );

    spi_reg_bank #(.NUM_REGS(NUM_REGS), .AW(ADDR_W), .DW(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .cfg_lsb_o(cfg_lsb), .cfg_four_wire_o(cfg_four_wire),
        .act_flat_o(act_regs_o)
    );

    assign spi_sdio_o = dout;
    assign spi_sdo_o  = dout;

endmodule

// File: tb/spi_reg_ctrl_tb_top.sv
`timescale 1ns/1ps
module spi_reg_ctrl_tb_top;

    localparam int NUM  = 8;
    localparam int BASE = 16;
    localparam int CFG  = 0;
    localparam int UPD  = 562;
    localparam int HP   = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdio_in = 1'b0;
    logic sdio_o, sdio_oe, sdo_o, sdo_oe;
    logic [NUM*8-1:0] act;

    always #2 clk = ~clk;

    spi_reg_ctrl #(.NUM_REGS(NUM)) dut_i (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk),
        .spi_sdio_i(sdio_in), .spi_sdio_o(sdio_o), .spi_sdio_oe(sdio_oe),
        .spi_sdo_o(sdo_o), .spi_sdo_oe(sdo_oe), .act_regs_o(act)
    );

    int n_tests = 0, n_fail = 0, cyc = 0, act_due = 0;
    bit mon_on = 0, act_pend = 0;
    logic [7:0] m_buf [NUM];
    logic [7:0] m_act [NUM];
    logic [7:0] act_new [NUM];
    logic [7:0] m_cfg = 8'h00;
    logic [7:0] wq [$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    function automatic logic [NUM*8-1:0] pk_act();
        logic [NUM*8-1:0] v;
        for (int i = 0; i < NUM; i++) v[i*8 +: 8] = m_act[i];
        return v;
    endfunction

    function automatic logic [NUM*8-1:0] pk_new();
        logic [NUM*8-1:0] v;
        for (int i = 0; i < NUM; i++) v[i*8 +: 8] = act_new[i];
        return v;
    endfunction

    function automatic logic [7:0] m_read(input logic [12:0] a);
        if (a[12:10] != 3'b0) return 8'h00;
        if (int'(a) == CFG) return m_cfg;
        if (int'(a) >= BASE && int'(a) < BASE + NUM) return m_buf[int'(a) - BASE];
        return 8'h00;
    endfunction

    task automatic m_write(input logic [12:0] a, input logic [7:0] d);
        if (a[12:10] != 3'b0) return;
        if (int'(a) == CFG) m_cfg = {6'b0, d[1:0]};
        if (int'(a) >= BASE && int'(a) < BASE + NUM) m_buf[int'(a) - BASE] = d;
        if (int'(a) == UPD && d[0]) begin
            for (int i = 0; i < NUM; i++) act_new[i] = m_buf[i];
            act_pend = 1;
            act_due  = cyc + 6;
        end
    endtask

    // Per-clock comparison of the active registers (R7, R8)
    always @(negedge clk) begin
        cyc++;
        if (mon_on) begin
            if (act_pend) begin
                if (cyc >= act_due) begin
                    chk(act == pk_new(), "R8", "active copy at due cycle", act, pk_new());
                    for (int i = 0; i < NUM; i++) m_act[i] = act_new[i];
                    act_pend = 0;
                end else if (act != pk_act() && act != pk_new()) begin
                    chk(0, "R8", "active value inside window", act, pk_new());
                end
            end else begin
                chk(act == pk_act(), "R7", "active value held", act, pk_act());
            end
        end
    end

    task automatic bit_cycle(input logic din, input bit commit, input logic [12:0] ca,
                             input logic [7:0] cd, output logic d3, output logic d4,
                             output logic oe3, output logic oe4);
        sdio_in = din;
        repeat (HP) @(negedge clk);
        d3 = sdio_o; d4 = sdo_o; oe3 = sdio_oe; oe4 = sdo_oe;
        sclk = 1'b1;
        if (commit) m_write(ca, cd);
        repeat (HP) @(negedge clk);
        sclk = 1'b0;
    endtask

    // One transfer; cut >= 0 raises chip-select before bit number cut
    task automatic xfer(input bit rd, input logic [1:0] w, input logic [12:0] a,
                        input int nsend, input int cut, input string req);
        logic [15:0] ins;
        logic [12:0] addr;
        logic [7:0]  exp, got, wd;
        logic        d3, d4, oe3, oe4, b;
        bit lsb, fw, stop, oe_ok, active;
        int total, limit;
        lsb = m_cfg[1]; fw = m_cfg[0]; stop = 0; total = 0;
        ins = {rd, w, a};
        cs_n = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            if (total == cut) begin stop = 1; break; end
            b = lsb ? ins[i] : ins[15-i];
            bit_cycle(b, 0, '0, '0, d3, d4, oe3, oe4);
            total++;
        end
        limit = (w == 2'b11) ? nsend : int'(w) + 1;
        addr = a;
        for (int k = 0; k < nsend && !stop; k++) begin
            active = (k < limit);
            exp = rd ? m_read(addr) : 8'h00;
            wd  = rd ? 8'h00 : wq[k];
            got = 8'h00; oe_ok = 1;
            for (int j = 0; j < 8; j++) begin
                int bi;
                if (total == cut) begin stop = 1; break; end
                bi = lsb ? j : 7 - j;
                bit_cycle(rd ? 1'b0 : wd[bi], !rd && active && j == 7, addr, wd,
                          d3, d4, oe3, oe4);
                total++;
                got[bi] = fw ? d4 : d3;
                if (rd && active) oe_ok = oe_ok && (fw ? (oe4 && !oe3) : (oe3 && !oe4));
                else              oe_ok = oe_ok && !oe3 && !oe4;
            end
            if (!stop) begin
                if (rd && active) chk(got == exp, req, "read byte", got, exp);
                chk(oe_ok, active ? "R10" : "R2", "output enables during byte", oe_ok, 1);
                if (active) addr = lsb ? addr + 1'b1 : addr - 1'b1;
            end
        end
        cs_n = 1'b1;
        repeat (2 * HP) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NUM; i++) begin m_buf[i] = 0; m_act[i] = 0; act_new[i] = 0; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk(!sdio_oe && !sdo_oe, "R12", "output enables after reset", {sdio_oe, sdo_oe}, 0);
        chk(act == '0, "R12", "active registers after reset", act, 0);
        xfer(1, 2'b00, 13'(CFG), 1, -1, "R12");
        // R1, R2: single-byte write with an ignored extra byte
        wq = '{8'hA5, 8'h3C};
        xfer(0, 2'b00, 13'(BASE + 2), 2, -1, "R2");
        xfer(1, 2'b00, 13'(BASE + 2), 2, -1, "R1");
        xfer(1, 2'b00, 13'(BASE + 1), 1, -1, "R2");
        // R3, R4: streaming write and read, address falling
        wq = '{8'h11, 8'h22, 8'h33, 8'h44};
        xfer(0, 2'b11, 13'(BASE + 7), 4, -1, "R3");
        xfer(1, 2'b11, 13'(BASE + 7), 4, -1, "R4");
        xfer(1, 2'b01, 13'(BASE + 5), 2, -1, "R9");
        chk(act == '0, "R7", "shadow writes not active", act, 0);
        // R8: commit with bit 0 clear, then set
        wq = '{8'h02};
        xfer(0, 2'b00, 13'(UPD), 1, -1, "R8");
        repeat (10) @(negedge clk);
        chk(act == '0, "R8", "commit with bit0 clear", act, 0);
        wq = '{8'h01};
        xfer(0, 2'b00, 13'(UPD), 1, -1, "R8");
        repeat (10) @(negedge clk);
        chk(act == pk_act(), "R8", "commit copied shadow", act, pk_act());
        xfer(1, 2'b00, 13'(UPD), 1, -1, "R8");
        // R6: upper address bits
        wq = '{8'hFF};
        xfer(0, 2'b00, 13'h800 | 13'(BASE), 1, -1, "R6");
        xfer(1, 2'b00, 13'(BASE), 1, -1, "R6");
        xfer(1, 2'b00, 13'h400 | 13'(BASE + 2), 1, -1, "R6");
        // R11: aborts in the data phase and in the instruction
        wq = '{8'h77};
        xfer(0, 2'b00, 13'(BASE), 1, 21, "R11");
        xfer(1, 2'b00, 13'(BASE), 1, -1, "R11");
        xfer(0, 2'b00, 13'(BASE), 1, 8, "R11");
        wq = '{8'h5A};
        xfer(0, 2'b00, 13'(BASE + 1), 1, -1, "R11");
        xfer(1, 2'b00, 13'(BASE + 1), 1, -1, "R11");
        // R10: separate read output
        wq = '{8'h01};
        xfer(0, 2'b00, 13'(CFG), 1, -1, "R10");
        xfer(1, 2'b00, 13'(BASE + 2), 1, -1, "R10");
        // R5: LSB first, address rising
        wq = '{8'h03};
        xfer(0, 2'b00, 13'(CFG), 1, -1, "R5");
        wq = '{8'hC1, 8'hD2, 8'hE3};
        xfer(0, 2'b10, 13'(BASE), 3, -1, "R5");
        xfer(1, 2'b10, 13'(BASE), 3, -1, "R5");
        wq = '{8'h01};
        xfer(0, 2'b00, 13'(UPD), 1, -1, "R8");
        repeat (10) @(negedge clk);
        chk(act == pk_act(), "R8", "commit in LSB-first mode", act, pk_act());
        // back to MSB first on the shared line
        wq = '{8'h00};
        xfer(0, 2'b00, 13'(CFG), 1, -1, "R5");
        xfer(1, 2'b01, 13'(BASE), 2, -1, "R4");
        repeat (20) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule